// File: doc/BRIEF.md
# Masked Local Interrupt Controller

This block merges sixteen level-sensitive interrupt request lines into one interrupt output for a processor. Each request line is sampled into a source register on every clock, so a source bit always tracks its line one cycle late. A software-owned enable mask gates the source bits. The gated set is the pending set, and the output is raised whenever that set is non-empty.

Software uses a small 16-bit register port with one select bit. With the select at the mask position, it can write and read back the enable mask. With the select at the vector position, a read returns a code for the lowest-numbered pending source. That code is the source number plus one, shifted left by two, or zero when nothing is pending. The interrupt service routine can use the code directly as a word offset into a handler table. Reading the vector acknowledges nothing. A source stays pending for as long as its request line is held high.

Top module: `mirq_ctrl`

## Requirements
- R1: Source bit n equals request input n as sampled at the previous rising clock edge. Raising or dropping a line is therefore seen at the output one clock later.
- R2: The pending set is the source bits ANDed with the enable mask. A source whose mask bit is 0 affects neither the interrupt output nor the vector.
- R3: `irq_o` is high exactly when the pending set is non-zero. It changes in the same cycle that a new source value or a new mask value takes effect, with no further register stage.
- R4: A read with `sel_i` = 0 (vector position) returns (n+1)<<2, where n is the selected pending source. This gives 4 for source 0 and 64 for source 15. The read returns 0 when nothing is pending.
- R5: A write with `sel_i` = 1 (mask position) loads `wdata_i` into the enable mask at that clock edge. A read with `sel_i` = 1 returns the current mask.
- R6: When several sources are pending, the vector names the lowest-numbered one.
- R7: While `rst_n` is low at a rising edge (synchronous, active low), the source bits clear to 0, the mask loads 0x0010, `rdata_o` clears to 0, and `irq_o` is low.
- R8: Reading the vector has no side effect. Repeated vector reads return the same value, and the source bits and output are unchanged.
- R9: A write with `sel_i` = 0 is ignored. The mask and the vector are unchanged afterwards.
- R10: `rdata_o` is registered. It takes the selected value at the edge where `rd_en_i` is high and holds that value until the next read or reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 16 | Level-sensitive interrupt request lines, bit n is source n |
| sel_i | input | 1 | Register select: 0 vector, 1 enable mask |
| wr_en_i | input | 1 | Write strobe for the selected register |
| rd_en_i | input | 1 | Read strobe for the selected register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Combined interrupt output |

## Verification
The assertions assume that the request lines are synchronous to `clk`, so each sampled source bit is the value the line held just before the edge. They also assume that the strobes and select are stable around the edge. Reset is assumed to be held for at least one edge before any checked behaviour. The stimulus changes every input only on falling edges. It holds the request lines steady for a full cycle before each vector read, so the read sees settled source bits. It never raises the read and write strobes together.

// File: rtl/mirq_pkg.sv
// Package: shared constants and types for the masked interrupt controller.
// Assumes a single clock domain and a register port as wide as the source count.
package mirq_pkg;
    parameter int NUM_SRC   = 16;
    parameter int REG_W     = 16;
    parameter int VEC_SHIFT = 2;
    parameter logic [REG_W-1:0] MASK_RST = 16'h0010;

    typedef enum logic {
        SEL_VECTOR = 1'b0,
        SEL_MASK   = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/mirq_src_latch.sv
// Module: samples the request lines into the source register every clock.
// Assumes req_i is already synchronous to clk; no edge detection is done.
module mirq_src_latch #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] src_o
);
    logic primed_q;

    // Source bits track the request levels, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) src_o <= '0;
        else        src_o <= req_i;
    end

    // Marks that the previous edge was outside reset.
    always_ff @(posedge clk) begin
        primed_q <= rst_n;
    end

    assert_src_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |-> src_o == $past(req_i));
endmodule

// File: rtl/mirq_mask_reg.sv
// Module: holds the software enable mask with a fixed reset value.
// Assumes wr_i is already qualified by the register select.
module mirq_mask_reg #(
    parameter int W = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_o
);
    logic primed_q;

    // Loads the mask on a qualified write, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)    mask_o <= RST_VAL;
        else if (wr_i) mask_o <= wdata_i;
    end

    // Marks that the previous edge was outside reset.
    always_ff @(posedge clk) begin
        primed_q <= rst_n;
    end

    assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(wr_i)) |-> mask_o == $past(wdata_i));
    assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && !$past(wr_i)) |-> $stable(mask_o));
endmodule

// File: rtl/mirq_prio_enc.sv
// Module: picks the lowest-numbered pending source and forms its vector code.
// Assumes VW is wide enough for (N << SHIFT); purely combinational.
module mirq_prio_enc #(
    parameter int N     = 16,
    parameter int VW    = 16,
    parameter int SHIFT = 2
) (
    input  logic [N-1:0]  pend_i,
    output logic [N-1:0]  grant_o,
    output logic          any_o,
    output logic [VW-1:0] vec_o
);
    localparam int IDX_W = $clog2(N + 1);

    logic [N:0]       seen;
    logic [IDX_W-1:0] idx;
    logic [VW-1:0]    idx_ext;

    assign seen[0] = 1'b0;

    // Prefix chain: a bit wins only if no lower bit is pending.
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign grant_o[i]  = pend_i[i] & ~seen[i];
        assign seen[i + 1] = seen[i] | pend_i[i];
    end

    assign any_o = seen[N];

    // Converts the one-hot grant into a binary source number.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant_o[i]) idx = idx | IDX_W'(i);
        end
    end

    // Forms (n+1) << SHIFT, or zero with nothing pending.
    always_comb begin
        idx_ext = VW'(idx);
        vec_o   = any_o ? ((idx_ext + VW'(1)) << SHIFT) : '0;
    end

    always_comb begin
        assert_grant_single_R6: assert ($onehot0(grant_o));
        assert_grant_pending_R2: assert ((grant_o & ~pend_i) == '0);
    end
endmodule

// File: rtl/mirq_ctrl.sv
// Module: masked local interrupt controller top level.
// Combines the source register, the enable mask and the priority encoder, and
// serves a 16-bit register port with registered read data.
// Assumes that the strobes are synchronous and that read and write are not issued together.
module mirq_ctrl
    import mirq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] req_i,
    input  logic        sel_i,
    input  logic        wr_en_i,
    input  logic        rd_en_i,
    input  logic [15:0] wdata_i,
    output logic [15:0] rdata_o,
    output logic        irq_o
);
    reg_sel_e           sel;
    logic [NUM_SRC-1:0] src;
    logic [NUM_SRC-1:0] mask;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] grant;
    logic               any_pend;
    logic [REG_W-1:0]   vec;
    logic               wr_mask;
    logic               started_q;

    assign sel     = reg_sel_e'(sel_i);
    assign wr_mask = wr_en_i && (sel == SEL_MASK);

    mirq_src_latch #(.N(NUM_SRC)) u_src (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req_i),
        .src_o (src)
    );

    mirq_mask_reg #(.W(REG_W), .RST_VAL(MASK_RST)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_mask),
        .wdata_i (wdata_i),
        .mask_o  (mask)
    );

    // Gates the sources by the enable mask.
    always_comb pend = src & mask;

    mirq_prio_enc #(.N(NUM_SRC), .VW(REG_W), .SHIFT(VEC_SHIFT)) u_enc (
        .pend_i  (pend),
        .grant_o (grant),
        .any_o   (any_pend),
        .vec_o   (vec)
    );

    // Drives the combined interrupt from the encoder's any-pending flag.
    always_comb irq_o = any_pend;

    // Captures the selected register on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_o <= '0;
        else if (rd_en_i) rdata_o <= (sel == SEL_MASK) ? mask : vec;
    end

    // Marks that at least one edge has passed.
    always_ff @(posedge clk) begin
        started_q <= 1'b1;
    end

    assert_irq_vector_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (vec != '0));
    assert_idle_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (vec == '0));
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && $past(rst_n) && !$past(rd_en_i)) |-> $stable(rdata_o));
    assert_reset_state_R7: assert property (@(posedge clk)
        (started_q && !$past(rst_n)) |-> (src == '0 && mask == MASK_RST && rdata_o == '0 && !irq_o));
endmodule

// File: tb/sim_mirq_ctrl.sv
// Scoreboard bench: read tasks push expected data, a monitor pops and compares.
module sim_mirq_ctrl;
    typedef struct packed {
        logic [15:0] val;
        logic [7:0]  rnum;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req = '0;
    logic        sel = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;
    logic        rd_seen = 1'b0;

    int checks = 0;
    int errors = 0;
    exp_t exp_q[$];
    logic [15:0] m_src = '0;
    logic [15:0] m_mask = 16'h0010;

    always #2 clk = ~clk;

    mirq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .sel_i(sel),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [15:0] ref_vec(input logic [15:0] s, input logic [15:0] m);
        for (int i = 0; i < 16; i++) begin
            if (s[i] && m[i]) return 16'((i + 1) * 4);
        end
        return 16'h0000;
    endfunction

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input int rn);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d: actual 0x%04h expected 0x%04h", rn, act, exp);
        end
    endtask

    task automatic set_req(input logic [15:0] v);
        req = v;
        @(negedge clk);
        m_src = rst_n ? v : 16'h0000;
    endtask

    task automatic wr(input logic s, input logic [15:0] d);
        sel = s; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (s) m_mask = d;
    endtask

    task automatic rd(input logic s, input int rn);
        exp_t e;
        e.val  = s ? m_mask : ref_vec(m_src, m_mask);
        e.rnum = 8'(rn);
        exp_q.push_back(e);
        sel = s; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Records which edges carried a read strobe.
    always @(posedge clk) rd_seen <= rd_en && rst_n;

    // Monitor: compares read data half a cycle after each read edge.
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10: read data 0x%04h with no expected entry", rdata);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rdata, e.val, int'(e.rnum));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check({15'd0, irq}, 16'd0, 7);          // R7 irq low in reset
        check(rdata, 16'd0, 7);                 // R7 read data cleared
        rst_n = 1'b1;
        @(negedge clk);
        rd(1'b1, 7);                            // R7 mask reset value 0x0010
        rd(1'b0, 4);                            // R4 nothing pending gives 0
        set_req(16'h0010);
        check({15'd0, irq}, 16'd1, 3);          // R3 enabled source raises irq
        rd(1'b0, 4);                            // R4 source 4 gives 20
        set_req(16'h0001);
        check({15'd0, irq}, 16'd0, 2);          // R2 masked source ignored
        rd(1'b0, 2);                            // R2 vector 0 when masked
        wr(1'b1, 16'hFFFF);
        check({15'd0, irq}, 16'd1, 3);          // R3 mask change re-evaluates
        rd(1'b1, 5);                            // R5 mask read-back
        rd(1'b0, 4);                            // R4 source 0 gives 4
        set_req(16'h8100);
        rd(1'b0, 6);                            // R6 lowest of 8 and 15 wins
        set_req(16'h8000);
        rd(1'b0, 4);                            // R4 source 15 gives 64
        rd(1'b0, 8);                            // R8 repeat read same value
        check({15'd0, irq}, 16'd1, 8);          // R8 irq unchanged by reads
        wr(1'b0, 16'h1234);
        rd(1'b1, 9);                            // R9 mask untouched
        rd(1'b0, 9);                            // R9 vector untouched
        set_req(16'h0000);
        check({15'd0, irq}, 16'd0, 1);          // R1 dropped line clears source
        @(negedge clk);
        check(rdata, 16'd64, 10);               // R10 rdata held without read
        set_req(16'hFFFF);
        wr(1'b1, 16'h0000);
        check({15'd0, irq}, 16'd0, 2);          // R2 all masked
        wr(1'b1, 16'h0100);
        check({15'd0, irq}, 16'd1, 5);          // R5 new mask effective
        rd(1'b0, 5);                            // R5 vector of source 8
        rst_n = 1'b0;
        @(negedge clk);
        m_src = 16'h0000; m_mask = 16'h0010;
        check({15'd0, irq}, 16'd0, 7);          // R7 reset mid-run
        check(rdata, 16'd0, 7);                 // R7 read data cleared
        rst_n = 1'b1;
        set_req(16'hFFFF);
        check({15'd0, irq}, 16'd1, 1);          // R1 sources follow after reset
        rd(1'b0, 7);                            // R7 reset mask selects source 4
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule